// File: doc/BRIEF.md
# Dual-Polarization Spectrum Packer

This block sits between a channelizer and a UDP transmit path. The channelizer delivers one spectrum at a time. Each 32-bit input beat carries one frequency channel and holds the complex sample of both polarizations. The block turns every spectrum into one 64-bit AXI4-Stream payload in three parts:

- a 64-bit running frame number;
- every channel of polarization A, in the order the channels arrived;
- every channel of polarization B, in the same order.

All multi-byte fields go out least significant byte first.

Two storage banks hold whole spectra and are used in ping-pong order, so a new spectrum can arrive while the previous payload is still draining. Input is ignored until an arm pulse. The arm pulse restarts the frame number at zero, and only complete, correctly terminated spectra are turned into packets. The input side has no ready signal, because the channelizer cannot be stalled. When a spectrum starts while both banks still hold unsent data, that spectrum is dropped and a one-cycle overflow pulse is raised.

The capture machine has three states:

- **CAP_OFF**: not yet armed. It moves to CAP_IDLE on arm.
- **CAP_IDLE**: waiting for a channel-0 beat. It moves to CAP_FILL on a channel-0 beat when the target bank is free. When the target bank is still full, it stays in CAP_IDLE and flags overflow.
- **CAP_FILL**: storing channels. It returns to CAP_IDLE on the final channel, when it commits the bank if tlast is present. It also returns to CAP_IDLE early on a premature tlast, and then abandons the spectrum.

The emit machine has four states:

- **EM_IDLE**: moves to EM_HDR when the next bank in order is full.
- **EM_HDR**: sends the header beat, then moves to EM_POLA on handshake.
- **EM_POLA**: sends the polarization A beats, then moves to EM_POLB after the last A beat.
- **EM_POLB**: sends the polarization B beats. After the last B beat it releases the bank, increments the frame number and returns to EM_IDLE.

An arm pulse forces both machines back to their start: CAP_IDLE and EM_IDLE.

Top module: `spectrum_packer`

## Requirements
- R1: After reset m_tvalid and ovf are low. Spectra that arrive before the first arm pulse produce no output beat.
- R2: Every packet is exactly 1 + NCHAN/2 beats long. m_tkeep is 8'hFF on every beat, and m_tlast is high on the final beat only.
- R3: Beat 0 of each packet carries the frame number as an unsigned 64-bit little-endian value, so m_tdata[7:0] is its least significant byte. The first packet after arm carries 0, and each later packet carries one more than the previous one.
- R4: Beats 1 to NCHAN/4 carry polarization A. Beat 1+w holds channels 4w to 4w+3, with channel 4w+k in m_tdata[16k+15:16k]. Within each lane the real byte is in the low half, taken from input bits [7:0], and the imaginary byte is in the high half, taken from input bits [15:8].
- R5: Beats NCHAN/4+1 to NCHAN/2 carry polarization B in the same channel and lane arrangement. The real byte is taken from input bits [23:16] and the imaginary byte from input bits [31:24].
- R6: A spectrum starts on the first valid beat after reset or after a tlast beat. A spectrum is packetized only if it has exactly NCHAN beats with tlast on the last one. A spectrum whose tlast comes early, or is missing on beat NCHAN-1, produces no packet.
- R7: A spectrum arriving back-to-back with the previous one is accepted while the previous packet drains. No data is lost when m_tready is high, and a bank is never written while it is being read out.
- R8: If a spectrum starts while both banks hold unsent spectra, that whole spectrum is dropped. ovf is high for exactly one cycle, the cycle after its channel-0 beat, and the frame number does not advance for it.
- R9: An arm pulse restarts the frame number at 0 and abandons any spectrum that is partially captured.
- R10: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle start pulse: enables capture and zeroes the frame number |
| s_tvalid | input | 1 | Input beat valid (the source cannot be stalled) |
| s_tdata | input | 32 | {B imag, B real, A imag, A real}, one channel per beat |
| s_tlast | input | 1 | Marks channel NCHAN-1 of a spectrum |
| m_tready | input | 1 | Downstream ready |
| m_tvalid | output | 1 | Output beat valid |
| m_tdata | output | 64 | Header or four channels of one polarization |
| m_tkeep | output | 8 | Byte enables, all set |
| m_tlast | output | 1 | Final beat of a packet |
| ovf | output | 1 | One-cycle pulse when a spectrum is dropped for lack of a free bank |

## Verification
The checks assume the following about the inputs:

- Channel beats of a spectrum may have gaps, but never arrive out of order.
- The first beat seen after reset is channel 0.
- arm is pulsed only when no output packet is in flight, because the tlast-position and header-zero checks count beats from the arm.

The stimulus keeps within these limits. It starts every stream on a spectrum boundary and waits for the output to drain before each arm, except for one arm that cuts into a spectrum being captured while the output is idle. The tests use a small configuration, NCHAN of 16, so every channel, lane and byte of every packet is compared with values the bench computes from the spectrum tag and the channel index.

// File: rtl/spk_pkg.sv
`timescale 1ns/1ps
package spk_pkg;
    localparam int IN_W   = 32;
    localparam int OUT_W  = 64;
    localparam int LANE_W = 16;
    localparam int LANES  = OUT_W / LANE_W;
    localparam int NBANK  = 2;

    typedef enum logic [1:0] {
        CAP_OFF,
        CAP_IDLE,
        CAP_FILL
    } cap_state_t;

    typedef enum logic [1:0] {
        EM_IDLE,
        EM_HDR,
        EM_POLA,
        EM_POLB
    } em_state_t;
endpackage

// File: rtl/spk_capture.sv
`timescale 1ns/1ps
module spk_capture
    import spk_pkg::*;
#(
    parameter int NCHAN = 2048,
    localparam int CH_W = $clog2(NCHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              s_tvalid,
    input  logic [IN_W-1:0]   s_tdata,
    input  logic              s_tlast,
    input  logic [NBANK-1:0]  bank_full,
    output logic              wr_en,
    output logic              wr_bank,
    output logic [CH_W-1:0]   wr_ch,
    output logic [IN_W-1:0]   wr_data,
    output logic              commit,
    output logic              commit_bank,
    output logic              ovf
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCHAN - 1);

    cap_state_t      state_q, state_d;
    logic [CH_W-1:0] ch_q, ch_d;
    logic            sel_q, sel_d;
    logic            sof_q;
    logic            ovf_q, ovf_d;
    logic            sof_beat;

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_OFF;
            ch_q    <= '0;
            sel_q   <= 1'b0;
            sof_q   <= 1'b1;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
            sel_q   <= sel_d;
            ovf_q   <= ovf_d;
            if (s_tvalid) sof_q <= s_tlast;
        end
    end

    // next state and write control
    always_comb begin
        state_d  = state_q;
        ch_d     = ch_q;
        sel_d    = sel_q;
        wr_en    = 1'b0;
        commit   = 1'b0;
        ovf_d    = 1'b0;
        sof_beat = s_tvalid && sof_q && !s_tlast;
        if (arm) begin
            state_d = CAP_IDLE;
            ch_d    = '0;
            sel_d   = 1'b0;
        end else begin
            unique case (state_q)
                CAP_OFF: state_d = CAP_OFF;
                CAP_IDLE: begin
                    if (sof_beat) begin
                        if (bank_full[sel_q]) begin
                            ovf_d = 1'b1;
                        end else begin
                            wr_en   = 1'b1;
                            ch_d    = CH_W'(1);
                            state_d = CAP_FILL;
                        end
                    end
                end
                CAP_FILL: begin
                    if (s_tvalid) begin
                        wr_en = 1'b1;
                        if (ch_q == LAST_CH) begin
                            state_d = CAP_IDLE;
                            if (s_tlast) begin
                                commit = 1'b1;
                                sel_d  = ~sel_q;
                            end
                        end else if (s_tlast) begin
                            state_d = CAP_IDLE;
                        end else begin
                            ch_d = ch_q + CH_W'(1);
                        end
                    end
                end
                default: state_d = CAP_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_bank     = sel_q;
        wr_ch       = (state_q == CAP_FILL) ? ch_q : '0;
        wr_data     = s_tdata;
        commit_bank = sel_q;
        ovf         = ovf_q;
    end
endmodule

// File: rtl/spk_store.sv
`timescale 1ns/1ps
module spk_store
    import spk_pkg::*;
#(
    parameter int NCHAN = 2048,
    localparam int CH_W   = $clog2(NCHAN),
    localparam int NWORD  = NCHAN / LANES,
    localparam int WORD_W = $clog2(NWORD),
    localparam int ADDR_W = WORD_W + 2,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [IN_W-1:0]   wr_data,
    input  logic              rd_bank,
    input  logic              rd_pol,
    input  logic [WORD_W-1:0] rd_word,
    output logic [OUT_W-1:0]  rd_data
);
    logic [OUT_W-1:0]  mem_q [DEPTH];
    logic [WORD_W-1:0] w_word;
    logic [1:0]        w_lane;
    logic [ADDR_W-1:0] a_idx, b_idx;

    assign w_word = wr_ch[CH_W-1:2];
    assign w_lane = wr_ch[1:0];
    assign a_idx  = {wr_bank, 1'b0, w_word};
    assign b_idx  = {wr_bank, 1'b1, w_word};

    // one input beat fills the same lane of an A word and a B word
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[a_idx][w_lane*LANE_W +: LANE_W] <= wr_data[LANE_W-1:0];
            mem_q[b_idx][w_lane*LANE_W +: LANE_W] <= wr_data[IN_W-1:LANE_W];
        end
    end

    assign rd_data = mem_q[{rd_bank, rd_pol, rd_word}];
endmodule

// File: rtl/spk_emit.sv
`timescale 1ns/1ps
module spk_emit
    import spk_pkg::*;
#(
    parameter int NCHAN = 2048,
    localparam int NWORD  = NCHAN / LANES,
    localparam int WORD_W = $clog2(NWORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [NBANK-1:0]  bank_full,
    input  logic              m_tready,
    input  logic [OUT_W-1:0]  rd_data,
    output logic              rd_bank,
    output logic              rd_pol,
    output logic [WORD_W-1:0] rd_word,
    output logic              m_tvalid,
    output logic [OUT_W-1:0]  m_tdata,
    output logic              m_tlast,
    output logic              release_pulse,
    output logic              release_bank,
    output logic              busy
);
    localparam logic [WORD_W-1:0] LAST_W = WORD_W'(NWORD - 1);

    em_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q, word_d;
    logic             sel_q, sel_d;
    logic [63:0]      frame_q, frame_d;
    logic             hs;

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EM_IDLE;
            word_q  <= '0;
            sel_q   <= 1'b0;
            frame_q <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            sel_q   <= sel_d;
            frame_q <= frame_d;
        end
    end

    assign hs = m_tvalid && m_tready;

    // next state
    always_comb begin
        state_d       = state_q;
        word_d        = word_q;
        sel_d         = sel_q;
        frame_d       = frame_q;
        release_pulse = 1'b0;
        if (arm) begin
            state_d = EM_IDLE;
            word_d  = '0;
            sel_d   = 1'b0;
            frame_d = '0;
        end else begin
            unique case (state_q)
                EM_IDLE: if (bank_full[sel_q]) state_d = EM_HDR;
                EM_HDR: begin
                    if (hs) begin
                        state_d = EM_POLA;
                        word_d  = '0;
                    end
                end
                EM_POLA: begin
                    if (hs) begin
                        if (word_q == LAST_W) begin
                            state_d = EM_POLB;
                            word_d  = '0;
                        end else begin
                            word_d = word_q + WORD_W'(1);
                        end
                    end
                end
                EM_POLB: begin
                    if (hs) begin
                        if (word_q == LAST_W) begin
                            state_d       = EM_IDLE;
                            word_d        = '0;
                            sel_d         = ~sel_q;
                            frame_d       = frame_q + 64'd1;
                            release_pulse = 1'b1;
                        end else begin
                            word_d = word_q + WORD_W'(1);
                        end
                    end
                end
                default: state_d = EM_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        m_tvalid     = (state_q != EM_IDLE);
        m_tdata      = (state_q == EM_HDR) ? frame_q : rd_data;
        m_tlast      = (state_q == EM_POLB) && (word_q == LAST_W);
        rd_bank      = sel_q;
        rd_pol       = (state_q == EM_POLB);
        rd_word      = word_q;
        release_bank = sel_q;
        busy         = (state_q != EM_IDLE);
    end
endmodule

// File: rtl/spectrum_packer.sv
`timescale 1ns/1ps
module spectrum_packer
    import spk_pkg::*;
#(
    parameter int NCHAN = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        s_tvalid,
    input  logic [31:0] s_tdata,
    input  logic        s_tlast,
    input  logic        m_tready,
    output logic        m_tvalid,
    output logic [63:0] m_tdata,
    output logic [7:0]  m_tkeep,
    output logic        m_tlast,
    output logic        ovf
);
    localparam int CH_W   = $clog2(NCHAN);
    localparam int NWORD  = NCHAN / LANES;
    localparam int WORD_W = $clog2(NWORD);

    logic [NBANK-1:0]  bank_full;
    logic [NBANK-1:0]  set_m, clr_m;
    logic              cap_we, cap_wbank, cap_commit, cap_cbank;
    logic [CH_W-1:0]   cap_wch;
    logic [IN_W-1:0]   cap_wdata;
    logic              em_rbank, em_rpol, em_rel, em_relbank, em_busy;
    logic [WORD_W-1:0] em_rword;
    logic [OUT_W-1:0]  st_rdata;

    spk_capture #(.NCHAN(NCHAN)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .s_tvalid    (s_tvalid),
        .s_tdata     (s_tdata),
        .s_tlast     (s_tlast),
        .bank_full   (bank_full),
        .wr_en       (cap_we),
        .wr_bank     (cap_wbank),
        .wr_ch       (cap_wch),
        .wr_data     (cap_wdata),
        .commit      (cap_commit),
        .commit_bank (cap_cbank),
        .ovf         (ovf)
    );

    spk_store #(.NCHAN(NCHAN)) u_store (
        .clk     (clk),
        .wr_en   (cap_we),
        .wr_bank (cap_wbank),
        .wr_ch   (cap_wch),
        .wr_data (cap_wdata),
        .rd_bank (em_rbank),
        .rd_pol  (em_rpol),
        .rd_word (em_rword),
        .rd_data (st_rdata)
    );

    spk_emit #(.NCHAN(NCHAN)) u_emit (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm           (arm),
        .bank_full     (bank_full),
        .m_tready      (m_tready),
        .rd_data       (st_rdata),
        .rd_bank       (em_rbank),
        .rd_pol        (em_rpol),
        .rd_word       (em_rword),
        .m_tvalid      (m_tvalid),
        .m_tdata       (m_tdata),
        .m_tlast       (m_tlast),
        .release_pulse (em_rel),
        .release_bank  (em_relbank),
        .busy          (em_busy)
    );

    // bank occupancy: set by capture commit, cleared by emit release
    assign set_m = {cap_commit && cap_cbank, cap_commit && !cap_cbank};
    assign clr_m = {em_rel && em_relbank, em_rel && !em_relbank};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   bank_full <= '0;
        else if (arm) bank_full <= '0;
        else          bank_full <= (bank_full | set_m) & ~clr_m;
    end

    assign m_tkeep = '1;
endmodule

// File: rtl/spectrum_packer_chk.sv
`timescale 1ns/1ps
module spectrum_packer_chk #(
    parameter int NCHAN = 2048,
    localparam int BEATS = 1 + NCHAN / 2,
    localparam int CNT_W = $clog2(BEATS + 1)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        arm,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic [63:0] m_tdata,
    input logic        m_tlast,
    input logic        ovf,
    input logic [1:0]  bank_full,
    input logic        cap_we,
    input logic        cap_wbank,
    input logic        em_busy,
    input logic        em_rbank
);
    logic [CNT_W-1:0] beat_q;
    logic             first_q;
    logic             armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= '0;
            first_q <= 1'b0;
            armed_q <= 1'b0;
        end else if (arm) begin
            beat_q  <= '0;
            first_q <= 1'b1;
            armed_q <= 1'b1;
        end else if (m_tvalid && m_tready) begin
            if (m_tlast) begin
                beat_q  <= '0;
                first_q <= 1'b0;
            end else begin
                beat_q <= beat_q + CNT_W'(1);
            end
        end
    end

    p_quiet_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !m_tvalid);

    p_tlast_place_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && !arm) |-> (m_tlast == (beat_q == CNT_W'(BEATS - 1))));

    p_first_header_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && !arm && first_q && beat_q == '0) |-> (m_tdata == 64'd0));

    p_no_write_read_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_we && em_busy) |-> (cap_wbank != em_rbank));

    p_ovf_both_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ($past(bank_full) == 2'b11));

    p_hold_under_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready && !arm) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
endmodule

bind spectrum_packer spectrum_packer_chk #(.NCHAN(NCHAN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .m_tvalid  (m_tvalid),
    .m_tready  (m_tready),
    .m_tdata   (m_tdata),
    .m_tlast   (m_tlast),
    .ovf       (ovf),
    .bank_full (bank_full),
    .cap_we    (cap_we),
    .cap_wbank (cap_wbank),
    .em_busy   (em_busy),
    .em_rbank  (em_rbank)
);

// File: tb/test_spectrum_packer.sv
`timescale 1ns/1ps
module test_spectrum_packer;
    localparam int NCHAN = 16;
    localparam int NW    = NCHAN / 4;
    localparam int BEATS = 1 + NCHAN / 2;

    logic        clk = 1'b0;
    logic        rst_n, arm, s_tvalid, s_tlast, m_tready;
    logic [31:0] s_tdata;
    logic        m_tvalid, m_tlast, ovf;
    logic [63:0] m_tdata;
    logic [7:0]  m_tkeep;

    always #2 clk = ~clk;

    spectrum_packer #(.NCHAN(NCHAN)) i_spectrum_packer (
        .clk(clk), .rst_n(rst_n), .arm(arm),
        .s_tvalid(s_tvalid), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .m_tready(m_tready), .m_tvalid(m_tvalid), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tlast(m_tlast), .ovf(ovf)
    );

    int          n_chk = 0, n_fail = 0;
    int          exp_q[$];
    logic [63:0] exp_hdr = 64'd0;
    int          bi = 0, cur_tag = -1;
    int          hs_cnt = 0, ovf_cnt = 0;
    bit          done = 0, bp_on = 0, rdy_force = 1'b1;
    logic [7:0]  lfsr = 8'hA5;
    logic        stall_q = 1'b0, stall_l;
    logic [63:0] stall_d;

    function automatic logic [7:0] a_re(int t, int ch);
        return {t[3:0], ch[3:0]};
    endfunction
    function automatic logic [7:0] a_im(int t, int ch);
        return a_re(t, ch) ^ 8'hFF;
    endfunction
    function automatic logic [7:0] b_re(int t, int ch);
        return a_re(t, ch) ^ 8'h5A;
    endfunction
    function automatic logic [7:0] b_im(int t, int ch);
        return a_re(t, ch) + 8'h33;
    endfunction
    function automatic logic [31:0] in_beat(int t, int ch);
        return {b_im(t, ch), b_re(t, ch), a_im(t, ch), a_re(t, ch)};
    endfunction
    function automatic logic [63:0] exp_word(int t, bit pol, int w);
        logic [63:0] r;
        for (int k = 0; k < 4; k++) begin
            int ch = 4 * w + k;
            r[16*k +: 16] = pol ? {b_im(t, ch), b_re(t, ch)} : {a_im(t, ch), a_re(t, ch)};
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ready generator
    initial begin
        m_tready = 1'b0;
        forever begin
            @(negedge clk);
            if (bp_on) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                m_tready = lfsr[0];
            end else begin
                m_tready = rdy_force;
            end
        end
    end

    // output monitor
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (ovf) ovf_cnt++;
            if (stall_q)
                chk(m_tvalid && m_tdata == stall_d && m_tlast == stall_l, "R10",
                    "stalled beat changed", m_tdata, stall_d);
            stall_q = m_tvalid && !m_tready;
            stall_d = m_tdata;
            stall_l = m_tlast;
            if (m_tvalid && m_tready) begin
                hs_cnt++;
                if (bi == 0) begin
                    if (exp_q.size() == 0) begin
                        cur_tag = -1;
                        chk(1'b0, "R6", "unexpected packet", m_tdata, exp_hdr);
                    end else begin
                        cur_tag = exp_q.pop_front();
                    end
                    chk(m_tdata == exp_hdr, "R3", "header", m_tdata, exp_hdr);
                end else if (cur_tag >= 0) begin
                    if (bi <= NW)
                        chk(m_tdata == exp_word(cur_tag, 1'b0, bi - 1), "R4", "pol A word",
                            m_tdata, exp_word(cur_tag, 1'b0, bi - 1));
                    else
                        chk(m_tdata == exp_word(cur_tag, 1'b1, bi - NW - 1), "R5", "pol B word",
                            m_tdata, exp_word(cur_tag, 1'b1, bi - NW - 1));
                end
                chk(m_tkeep == 8'hFF, "R2", "tkeep", 64'(m_tkeep), 64'hFF);
                chk(m_tlast == (bi == BEATS - 1), "R2", "tlast position",
                    64'(m_tlast), 64'(bi == BEATS - 1));
                if (m_tlast) begin
                    bi = 0;
                    exp_hdr = exp_hdr + 64'd1;
                end else begin
                    bi++;
                end
            end
        end
    end

    task automatic send_spec(int tag, int nbeats, int last_at);
        for (int i = 0; i < nbeats; i++) begin
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tdata  = in_beat(tag, i);
            s_tlast  = (i == last_at);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_tvalid = 1'b0;
            s_tlast  = 1'b0;
        end
    endtask

    task automatic do_arm();
        @(negedge clk);
        s_tvalid = 1'b0;
        arm = 1'b1;
        exp_hdr = 64'd0;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic wait_drain();
        do @(negedge clk); while (exp_q.size() != 0 || bi != 0 || m_tvalid);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        rst_n = 1'b0; arm = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!m_tvalid && !ovf, "R1", "reset state", {62'd0, m_tvalid, ovf}, 64'd0);

        // R1: spectrum before arm is ignored
        send_spec(1, NCHAN, NCHAN - 1);
        idle(40);
        chk(hs_cnt == 0, "R1", "beats before arm", 64'(hs_cnt), 64'd0);

        // R7: back-to-back spectra with ready high
        do_arm();
        base = ovf_cnt;
        exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(4);
        send_spec(2, NCHAN, NCHAN - 1);
        send_spec(3, NCHAN, NCHAN - 1);
        send_spec(4, NCHAN, NCHAN - 1);
        idle(1);
        wait_drain();
        chk(hs_cnt == 3 * BEATS, "R7", "beats for 3 spectra", 64'(hs_cnt), 64'(3 * BEATS));
        chk(ovf_cnt == base, "R7", "no overflow back-to-back", 64'(ovf_cnt - base), 64'd0);

        // R10: pseudo-random backpressure
        bp_on = 1;
        for (int t = 5; t <= 7; t++) begin
            exp_q.push_back(t);
            send_spec(t, NCHAN, NCHAN - 1);
            idle(30);
        end
        wait_drain();
        bp_on = 0;

        // R8: both banks full, third spectrum dropped
        rdy_force = 1'b0;
        repeat (2) @(negedge clk);
        base = ovf_cnt;
        exp_q.push_back(8); exp_q.push_back(9);
        send_spec(8, NCHAN, NCHAN - 1);
        send_spec(9, NCHAN, NCHAN - 1);
        send_spec(10, NCHAN, NCHAN - 1);
        idle(5);
        chk(ovf_cnt - base == 1, "R8", "overflow pulse cycles", 64'(ovf_cnt - base), 64'd1);
        rdy_force = 1'b1;
        wait_drain();
        chk(exp_hdr == 64'd8, "R8", "frame count after drop", exp_hdr, 64'd8);

        // R6: early tlast and missing tlast are discarded
        exp_q.push_back(13);
        send_spec(11, 10, 9);
        send_spec(12, NCHAN + 4, NCHAN + 3);
        send_spec(13, NCHAN, NCHAN - 1);
        idle(1);
        wait_drain();
        chk(exp_hdr == 64'd9, "R6", "only whole spectrum packed", exp_hdr, 64'd9);

        // R9: arm in the middle of a capture, count restarts
        for (int i = 0; i < NCHAN; i++) begin
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tdata  = in_beat(14, i);
            s_tlast  = (i == NCHAN - 1);
            arm      = (i == 5);
            if (i == 5) exp_hdr = 64'd0;
        end
        @(negedge clk);
        arm = 1'b0;
        s_tvalid = 1'b0;
        s_tlast = 1'b0;
        exp_q.push_back(15);
        send_spec(15, NCHAN, NCHAN - 1);
        idle(1);
        wait_drain();
        chk(exp_hdr == 64'd1, "R9", "one packet after re-arm", exp_hdr, 64'd1);
        chk(exp_q.size() == 0, "R7", "all expected packets seen", 64'(exp_q.size()), 64'd0);

        done = 1;
        summary();
        $finish;
    end
endmodule